// File: doc/BRIEF.md
# Write-Through Four-Way Data Cache with Channel-Write Update

This block is a processor-side data cache. It sits between a CPU load/store port and a word-wide main-memory port. Lines are 32 bytes long and aligned to 32 bytes. They are held in a four-way set-associative array, and a parameter selects 64 or 128 sets. Loads that hit are answered from the array. Loads that miss fetch the whole line from memory, forward the wanted word as soon as it arrives, and install the line.

Every CPU store goes to memory. The array copy is patched only when the line is already resident, and a store miss leaves the array alone. A second write port, used by I/O channels, also writes memory only. When a channel write lands on a resident line, that line is patched in place rather than dropped.

A bypass input sends every CPU load straight to memory as a single-word read. While it is set, stores and channel writes still patch resident lines, so the array stays correct for the moment the bypass is released. All three ports use a request/acknowledge handshake. A requester holds its request until it sees a one-cycle acknowledge.

Top module: `wt_cache`

## Requirements
- R1: After reset, `cpu_ack`, `io_ack` and `mem_req` are low and no line is valid, so the first load to any address takes a full line fill.
- R2: The byte offset is address bits [4:0] and the set index is the next log2(SETS) bits. The remaining upper bits form the tag. Up to four distinct tags that share an index stay resident together, and lines with different indices never evict one another.
- R3: A load that hits raises `cpu_ack` with the word on `cpu_rdata` one cycle after the request is accepted, and it causes no memory transfer.
- R4: A load miss makes exactly 8 single-word memory reads. The first read is the requested word, and the following reads step upward and wrap within the line. `cpu_ack` carries the requested word one cycle after the first memory acknowledge, while the rest of the fill is still running. The line is then resident.
- R5: The way filled on a miss is the lowest-numbered invalid way, if any. Otherwise it is chosen by a 3-bit tree per set: the top bit picks the pair (0 = ways 0/1, 1 = ways 2/3), and the pair bit picks the lower way when 0. A load hit or a fill of way w steers the tree away from w.
- R6: A store makes one memory write with its byte enables (bit n enables byte lane n, bits [8n+7:8n]). `cpu_ack` follows the memory acknowledge by one cycle. A store hit updates the enabled cached bytes, and a store miss installs nothing.
- R7: A channel write makes one memory write with its byte enables and raises `io_ack` one cycle after the memory acknowledge. It patches a resident line and never installs one.
- R8: When a channel write and a CPU access are both pending in the idle state, the channel write is started first, so a load of the same word returns the channel's data.
- R9: While `cache_off` is high, each load makes a single one-word memory read and returns that word. Nothing is installed and no valid bit is cleared, so lines resident before the bypass still hit after it is released.
- R10: While `cache_off` is high, stores and channel writes still update resident lines.
- R11: Once `mem_req` is raised, `mem_req`, `mem_addr`, `mem_we`, `mem_wdata` and `mem_be` hold steady until `mem_ack`. Each acknowledge completes one word transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_off | input | 1 | Bypass: loads go straight to memory |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| io_req | input | 1 | Channel write request, held until `io_ack` |
| io_addr | input | ADDR_W | Channel byte address |
| io_wdata | input | 32 | Channel write data |
| io_be | input | 4 | Channel byte enables |
| io_ack | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address (bits [1:0] zero) |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A load hit answers on the cycle after acceptance. A store, a channel write and a bypassed load answer one cycle after their memory acknowledge. A miss answers one cycle after the first of its eight fill acknowledges. The bench samples everything on the falling edge and waits for each acknowledge instead of counting a fixed delay. After each acknowledge it waits for `mem_req` to fall before it reads its beat counters, so an early answer from a fill is still charged all eight reads. The memory model stalls every transfer for one extra falling edge, so the request fields can be compared while the transfer is pending.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BE_W       = WORD_W / 8;
  localparam int unsigned NWAYS      = 4;
  localparam int unsigned WAY_W      = 2;
  localparam int unsigned LINE_WORDS = 8;
  localparam int unsigned WSEL_W     = 3;
  localparam int unsigned OFF_W      = WSEL_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IOWR,
    ST_CPUWR,
    ST_FILL,
    ST_BYP
  } wtc_state_e;

  // byte-lane merge: lane n taken from nw when be[n] is set
  function automatic logic [WORD_W-1:0] merge_be(input logic [WORD_W-1:0] old,
                                                 input logic [WORD_W-1:0] nw,
                                                 input logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r;
    r = old;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // tree: bit0 picks pair (0 -> ways 0/1), bit1 inside low pair, bit2 inside high pair
  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t,
                                            input logic [WAY_W-1:0] w);
    logic [2:0] r;
    r = t;
    if (!w[1]) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/wtc_tag_dir.sv
module wtc_tag_dir
  import wtc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             set_en,
  input  logic [WAY_W-1:0] set_way,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [TAG_W-1:0] tag_q   [SETS][NWAYS];
  logic [NWAYS-1:0] valid_q [SETS];
  logic [2:0]       plru_q  [SETS];

  logic             any_free;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    any_free = 1'b0;
    free_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!valid_q[lk_idx][w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    victim_way = any_free ? free_way : plru_pick(plru_q[lk_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      if (set_en) valid_q[lk_idx][set_way] <= 1'b1;
      if (touch_en) plru_q[lk_idx] <= plru_touch(plru_q[lk_idx], touch_way);
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[lk_idx][set_way] <= lk_tag;
  end
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram
  import wtc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              we,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be
);
  localparam int DEPTH = SETS * NWAYS * LINE_WORDS;
  localparam int AW    = IDX_W + WAY_W + WSEL_W;

  logic [WORD_W-1:0] store_q [DEPTH];
  logic [AW-1:0]     rd_a, wr_a;

  assign rd_a    = {idx, rd_way, rd_word};
  assign wr_a    = {idx, wr_way, wr_word};
  assign rd_data = store_q[rd_a];

  always_ff @(posedge clk) begin
    if (we) store_q[wr_a] <= merge_be(store_q[wr_a], wr_data, wr_be);
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SETS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_off,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_ack,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              io_req,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [WORD_W-1:0] io_wdata,
  input  logic [BE_W-1:0]   io_be,
  output logic              io_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  wtc_state_e        state_q;
  logic [ADDR_W-1:0] req_q;
  logic [WSEL_W-1:0] beat_q;
  logic [WAY_W-1:0]  victim_q;

  // named events, also watched by the checker
  logic st_idle, st_byp, io_take, cpu_take, rd_hit_go, fill_start, byp_start;
  logic wr_start, fill_beat, fill_done;

  logic [ADDR_W-1:0] sel_addr, lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WSEL_W-1:0] lk_word, fill_word;
  logic              lk_hit;
  logic [WAY_W-1:0]  hit_way, lk_victim;
  logic [WORD_W-1:0] ram_rdata, wr_src_data;
  logic [BE_W-1:0]   wr_src_be;
  logic              unused_low;

  assign st_idle  = (state_q == ST_IDLE);
  assign st_byp   = (state_q == ST_BYP);
  assign io_take  = st_idle && io_req && !io_ack;
  assign cpu_take = st_idle && cpu_req && !cpu_ack && !io_take;

  assign sel_addr = io_take ? io_addr : cpu_addr;
  assign lk_addr  = st_idle ? sel_addr : req_q;
  assign lk_idx   = lk_addr[OFF_W +: IDX_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_word  = lk_addr[2 +: WSEL_W];

  assign rd_hit_go  = cpu_take && !cpu_we && !cache_off && lk_hit;
  assign fill_start = cpu_take && !cpu_we && !cache_off && !lk_hit;
  assign byp_start  = cpu_take && !cpu_we && cache_off;
  assign wr_start   = io_take || (cpu_take && cpu_we);
  assign fill_beat  = (state_q == ST_FILL) && mem_ack;
  assign fill_done  = fill_beat && (beat_q == WSEL_W'(LINE_WORDS - 1));
  assign fill_word  = req_q[2 +: WSEL_W] + beat_q;

  assign wr_src_data = io_take ? io_wdata : cpu_wdata;
  assign wr_src_be   = io_take ? io_be : cpu_be;
  assign unused_low  = ^{cpu_addr[1:0], io_addr[1:0], req_q[1:0]};

  wtc_tag_dir #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .set_en    (fill_done),
    .set_way   (victim_q),
    .touch_en  (rd_hit_go || fill_done),
    .touch_way (fill_done ? victim_q : hit_way),
    .hit       (lk_hit),
    .hit_way   (hit_way),
    .victim_way(lk_victim)
  );

  // one write port: patch on a write hit (any mode) or one fill word
  wtc_data_ram #(.SETS(SETS), .IDX_W(IDX_W)) data_i (
    .clk    (clk),
    .idx    (lk_idx),
    .rd_way (hit_way),
    .rd_word(lk_word),
    .rd_data(ram_rdata),
    .we     ((wr_start && lk_hit) || fill_beat),
    .wr_way (fill_beat ? victim_q : hit_way),
    .wr_word(fill_beat ? fill_word : lk_word),
    .wr_data(fill_beat ? mem_rdata : wr_src_data),
    .wr_be  (fill_beat ? {BE_W{1'b1}} : wr_src_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      beat_q    <= '0;
      victim_q  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      io_ack    <= 1'b0;
    end else begin
      cpu_ack <= 1'b0;
      io_ack  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_start) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {sel_addr[ADDR_W-1:2], 2'b00};
            mem_wdata <= wr_src_data;
            mem_be    <= wr_src_be;
            state_q   <= io_take ? ST_IOWR : ST_CPUWR;
          end else if (rd_hit_go) begin
            cpu_ack   <= 1'b1;
            cpu_rdata <= ram_rdata;
          end else if (byp_start || fill_start) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_be   <= {BE_W{1'b1}};
            mem_addr <= {cpu_addr[ADDR_W-1:2], 2'b00};
            req_q    <= cpu_addr;
            beat_q   <= '0;
            victim_q <= lk_victim;
            state_q  <= byp_start ? ST_BYP : ST_FILL;
          end
        end
        ST_IOWR, ST_CPUWR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (state_q == ST_IOWR) io_ack <= 1'b1;
            else cpu_ack <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_BYP: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_ack   <= 1'b1;
            cpu_rdata <= mem_rdata;
            state_q   <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            if (beat_q == '0) begin
              cpu_ack   <= 1'b1;
              cpu_rdata <= mem_rdata;
            end
            if (fill_done) begin
              mem_req <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              beat_q   <= beat_q + 1'b1;
              mem_addr <= {req_q[ADDR_W-1:OFF_W], fill_word + 1'b1, 2'b00};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              cpu_ack,
  input logic              io_ack,
  input logic [ADDR_W-1:0] io_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              io_take,
  input logic              cpu_take,
  input logic              rd_hit_go,
  input logic              st_byp
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_go |=> (cpu_ack && !mem_req)); // R3

  AST_STORE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_take && cpu_we) |=> (mem_req && mem_we)); // R6

  AST_IO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    io_take |=> (mem_req && mem_we && (mem_addr[ADDR_W-1:2] == $past(io_addr[ADDR_W-1:2])))); // R8

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_ack, io_ack})); // R8

  AST_BYP_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_byp && mem_ack) |=> (!mem_req && cpu_ack)); // R9
endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_we   (cpu_we),
  .cpu_ack  (cpu_ack),
  .io_ack   (io_ack),
  .io_addr  (io_addr),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .io_take  (io_take),
  .cpu_take (cpu_take),
  .rd_hit_go(rd_hit_go),
  .st_byp   (st_byp)
);

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  localparam int ADDR_W = 24;
  localparam int MWORDS = 4096;

  typedef struct packed {
    logic [1:0]  op;    // 0 load, 1 store, 2 channel write
    logic [15:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        hit;   // expected load hit
    logic [3:0]  req;   // requirement number in messages
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 16'h0004, 32'h0, 4'h0, 1'b0, 4'd1},   // R1 cold miss
    '{2'd0, 16'h0008, 32'h0, 4'h0, 1'b1, 4'd3},   // R3 same line hits
    '{2'd0, 16'h0804, 32'h0, 4'h0, 1'b0, 4'd2},   // R2 second tag, set 0
    '{2'd0, 16'h1000, 32'h0, 4'h0, 1'b0, 4'd2},   // R2 third tag
    '{2'd0, 16'h181C, 32'h0, 4'h0, 1'b0, 4'd4},   // R4 last word, wrapping fill
    '{2'd0, 16'h0000, 32'h0, 4'h0, 1'b1, 4'd3},   // R3 way 0 touched
    '{2'd0, 16'h2000, 32'h0, 4'h0, 1'b0, 4'd5},   // R5 evicts way 2 (0x1000)
    '{2'd0, 16'h0810, 32'h0, 4'h0, 1'b1, 4'd5},   // R5 way 1 survives
    '{2'd0, 16'h1804, 32'h0, 4'h0, 1'b1, 4'd5},   // R5 way 3 survives
    '{2'd0, 16'h0000, 32'h0, 4'h0, 1'b1, 4'd5},   // R5 way 0 survives
    '{2'd0, 16'h1008, 32'h0, 4'h0, 1'b0, 4'd5},   // R5 evicted line misses
    '{2'd1, 16'h0004, 32'hDEADBEEF, 4'hF, 1'b0, 4'd6}, // R6 store hit
    '{2'd0, 16'h0004, 32'h0, 4'h0, 1'b1, 4'd6},   // R6 cached copy patched
    '{2'd1, 16'h3004, 32'h0000ABCD, 4'h3, 1'b0, 4'd6}, // R6 store miss, low lanes
    '{2'd0, 16'h3004, 32'h0, 4'h0, 1'b0, 4'd6},   // R6 no allocation on store
    '{2'd2, 16'h0008, 32'h12345678, 4'hC, 1'b0, 4'd7}, // R7 channel hit, high lanes
    '{2'd0, 16'h0008, 32'h0, 4'h0, 1'b1, 4'd7},   // R7 patched in place
    '{2'd2, 16'h0040, 32'hCAFEF00D, 4'hF, 1'b0, 4'd7}, // R7 channel miss
    '{2'd0, 16'h0040, 32'h0, 4'h0, 1'b0, 4'd7},   // R7 channel never allocates
    '{2'd0, 16'h0020, 32'h0, 4'h0, 1'b0, 4'd2}    // R2 set 1 independent
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cache_off = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0]       cpu_wdata = '0;
  logic [3:0]        cpu_be = '0;
  logic              cpu_ack;
  logic [31:0]       cpu_rdata;
  logic              io_req = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [31:0]       io_wdata = '0;
  logic [3:0]        io_be = '0;
  logic              io_ack;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [3:0]        mem_be;
  logic              mem_ack = 1'b0;
  logic [31:0]       mem_rdata = '0;

  always #5 clk = ~clk;

  wt_cache #(.ADDR_W(ADDR_W), .SETS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .cache_off(cache_off),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .io_req(io_req), .io_addr(io_addr), .io_wdata(io_wdata), .io_be(io_be), .io_ack(io_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rd_beats = 0, wr_beats = 0;
  logic [31:0]       mem [0:MWORDS-1];
  logic [31:0]       ref_mem [0:MWORDS-1];
  logic              want_first = 1'b0;
  logic [ADDR_W-1:0] first_rd = '0;
  logic              pend = 1'b0;
  logic [ADDR_W-1:0] pend_addr = '0;
  logic [31:0]       pend_data = '0;
  logic              pend_we = 1'b0;

  function automatic logic [31:0] lane_merge(input logic [31:0] o, input logic [31:0] n,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory model: each transfer stalls one falling edge, then acknowledges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      check(1'b0, "watchdog", cyc, 60000);
      finish_run();
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1'b1;
        pend_addr = mem_addr;
        pend_data = mem_wdata;
        pend_we = mem_we;
      end else begin
        pend = 1'b0;
        check(mem_addr == pend_addr && mem_we == pend_we && mem_wdata == pend_data,
              "R11 request held", mem_addr, pend_addr);
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] = lane_merge(mem[mem_addr[13:2]], mem_wdata, mem_be);
          wr_beats++;
        end else begin
          mem_rdata = mem[mem_addr[13:2]];
          rd_beats++;
          if (want_first) begin
            first_rd = mem_addr;
            want_first = 1'b0;
          end
        end
      end
    end
  end

  task automatic cpu_load(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                          output int beats, output logic early);
    int r0;
    r0 = rd_beats;
    want_first = 1'b1;
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_ack);
    d = cpu_rdata;
    early = mem_req;
    cpu_req = 1'b0;
    while (mem_req) @(negedge clk);
    beats = rd_beats - r0;
  endtask

  task automatic cpu_store(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           input logic [3:0] be, output int wb, output int rb);
    int w0, r0;
    w0 = wr_beats; r0 = rd_beats;
    ref_mem[a[13:2]] = lane_merge(ref_mem[a[13:2]], d, be);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d; cpu_be = be; cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_ack);
    cpu_req = 1'b0;
    wb = wr_beats - w0; rb = rd_beats - r0;
  endtask

  task automatic chan_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                            input logic [3:0] be, output int wb, output int rb);
    int w0, r0;
    w0 = wr_beats; r0 = rd_beats;
    ref_mem[a[13:2]] = lane_merge(ref_mem[a[13:2]], d, be);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_be = be; io_req = 1'b1;
    do @(negedge clk); while (!io_ack);
    io_req = 1'b0;
    wb = wr_beats - w0; rb = rd_beats - r0;
  endtask

  initial begin
    logic [31:0]       d;
    logic              early;
    int                beats, wb, rb;
    logic [ADDR_W-1:0] a;
    string             tg;

    for (int i = 0; i < MWORDS; i++) begin
      mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      ref_mem[i] = mem[i];
    end

    repeat (3) @(negedge clk);
    check(!cpu_ack && !io_ack && !mem_req, "R1 reset outputs",
          {29'd0, cpu_ack, io_ack, mem_req}, 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      a = ADDR_W'(VECS[i].addr);
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        2'd0: begin
          cpu_load(a, d, beats, early);
          check(d == ref_mem[a[13:2]], {tg, " data"}, d, ref_mem[a[13:2]]);
          check(beats == (VECS[i].hit ? 0 : 8), {tg, " mem reads"}, beats,
                VECS[i].hit ? 0 : 8);
          if (!VECS[i].hit) begin
            check(early, {tg, " R4 early answer"}, {31'd0, early}, 32'd1);
            check(first_rd == {a[ADDR_W-1:2], 2'b00}, {tg, " R4 first word"}, first_rd,
                  {a[ADDR_W-1:2], 2'b00});
          end
        end
        2'd1: begin
          cpu_store(a, VECS[i].data, VECS[i].be, wb, rb);
          check(wb == 1 && rb == 0, {tg, " one write"}, wb, 1);
          check(mem[a[13:2]] == ref_mem[a[13:2]], {tg, " memory"}, mem[a[13:2]],
                ref_mem[a[13:2]]);
        end
        default: begin
          chan_write(a, VECS[i].data, VECS[i].be, wb, rb);
          check(wb == 1 && rb == 0, {tg, " one write"}, wb, 1);
          check(mem[a[13:2]] == ref_mem[a[13:2]], {tg, " memory"}, mem[a[13:2]],
                ref_mem[a[13:2]]);
        end
      endcase
    end

    // R8: channel write and CPU load of the same word raised together
    begin
      bit io_done, cpu_done, io_first;
      io_done = 0; cpu_done = 0; io_first = 0;
      ref_mem[2] = 32'h0BADC0DE;
      @(negedge clk);
      io_addr = 24'h000008; io_wdata = 32'h0BADC0DE; io_be = 4'hF; io_req = 1'b1;
      cpu_addr = 24'h000008; cpu_we = 1'b0; cpu_req = 1'b1;
      while (!(io_done && cpu_done)) begin
        @(negedge clk);
        if (io_ack) begin
          io_done = 1; io_req = 1'b0;
          if (!cpu_done) io_first = 1;
        end
        if (cpu_ack) begin
          cpu_done = 1; cpu_req = 1'b0; d = cpu_rdata;
        end
      end
      check(io_first, "R8 channel first", {31'd0, io_first}, 32'd1);
      check(d == 32'h0BADC0DE, "R8 load sees channel data", d, 32'h0BADC0DE);
    end

    // R9 / R10: bypass
    cache_off = 1'b1;
    cpu_load(24'h000004, d, beats, early);
    check(beats == 1 && d == ref_mem[1], "R9 bypass load", beats, 1);
    cpu_load(24'h002800, d, beats, early);
    check(beats == 1 && d == ref_mem[24'h2800 >> 2], "R9 bypass miss", beats, 1);
    cpu_store(24'h000004, 32'h55AA55AA, 4'hF, wb, rb);
    check(wb == 1, "R10 store while off", wb, 1);
    chan_write(24'h00000C, 32'h13579BDF, 4'hF, wb, rb);
    check(wb == 1, "R10 channel while off", wb, 1);
    cache_off = 1'b0;
    cpu_load(24'h000004, d, beats, early);
    check(beats == 0 && d == 32'h55AA55AA, "R10 store patched line", d, 32'h55AA55AA);
    cpu_load(24'h00000C, d, beats, early);
    check(beats == 0 && d == 32'h13579BDF, "R10 channel patched line", d, 32'h13579BDF);
    cpu_load(24'h002800, d, beats, early);
    check(beats == 8, "R9 no allocation while off", beats, 8);

    // R1: reset again empties the array
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!cpu_ack && !io_ack && !mem_req, "R1 reset outputs again",
          {29'd0, cpu_ack, io_ack, mem_req}, 32'd0);
    rst_n = 1'b1;
    cpu_load(24'h000008, d, beats, early);
    check(beats == 8 && d == ref_mem[2], "R1 miss after reset", beats, 8);

    finish_run();
  end
endmodule